// File: doc/BRIEF.md
# Undefined-Opcode Trap and Interrupt Control Unit

This unit sits beside the instruction decoder of an 8-bit CPU. When the decoder reports that it fetched an opcode it cannot execute, the unit latches a sticky trap flag. It also records which byte of the opcode was the bad one. It then runs a short sequence: it asks the stack logic to push the program counter that came with the report, and once the push is acknowledged it tells the fetch unit to restart at a fixed logical address. The decoder raises the same strobe for a bad opcode fetched during an external interrupt acknowledge in vectored-opcode mode, so the unit handles that case in the same way.

The unit also holds two registers that software can reach through a small register port. The control register carries the trap flag, the byte-position flag and three interrupt-enable bits. The vector register carries the three upper bits of the interrupt vector. The enable bits gate the raw interrupt request lines. The upper vector bits are joined to a source code supplied by an external priority encoder to form an 8-bit vector. Enabling or disabling interrupts never blocks trap generation.

Top module: `trap_ictl`

## Requirements
- R1: After reset, the control register (address 0) reads 8'h39, the vector register (address 1) reads 8'h00, and pushReq and redirect are low. The enable field resets to 3'b001.
- R2: When undefStrobe is high at a clock edge, control bit 7 (trap flag) reads 1 from the next cycle, whatever the enable bits hold. The same strobe also covers a bad opcode fetched during an interrupt acknowledge.
- R3: A write to the control register with data bit 7 = 0 clears the trap flag. A write with bit 7 = 1 leaves it unchanged, so it stays 0 if it was 0.
- R4: If undefStrobe and a control write with bit 7 = 0 fall on the same edge, the trap flag reads 1 afterwards.
- R5: Control bit 6 is read-only. When a trap sequence starts, it loads undefThirdByte (1 = third opcode byte, 0 = second opcode byte). Register writes never change it.
- R6: In the cycle after a strobe that starts a sequence, pushReq goes high and pushData equals the pcIn value given with that strobe. pushReq and pushData hold until pushAck is high at an edge.
- R7: In the cycle after the edge where pushReq and pushAck are both high, redirect is high for exactly one cycle with redirectAddr = 0, and pushReq is low.
- R8: A strobe that arrives while a sequence is in progress sets the trap flag. It does not change pushData or bit 6, and it starts no second sequence.
- R9: Control bits 2:0 are read/write interrupt enables. Control bits 5:3 always read 1.
- R10: irqMasked equals irqRaw AND the enable bits, bit by bit.
- R11: Vector register bits 7:5 are read/write, and its bits 4:0 read 0. The vector output is {vector bits 7:5, srcCode}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 1 | Register select: 0 = control, 1 = vector |
| regWrEn | input | 1 | Register write strobe |
| regWd | input | 8 | Register write data |
| regRdData | output | 8 | Read data of the selected register |
| undefStrobe | input | 1 | Decoder reports an undefined opcode fetch |
| undefThirdByte | input | 1 | With the strobe: 1 = third byte, 0 = second byte |
| pcIn | input | 16 | PC of the undefined opcode, valid with the strobe |
| pushReq | output | 1 | Request to push pushData onto the stack |
| pushData | output | 16 | PC value to push |
| pushAck | input | 1 | Stack logic accepts the push |
| redirect | output | 1 | One-cycle pulse: restart fetch |
| redirectAddr | output | 16 | Restart address (logical 0) |
| irqRaw | input | 3 | Raw interrupt request lines, one per level |
| irqMasked | output | 3 | Requests gated by the enable bits |
| srcCode | input | 5 | Source code from the priority encoder |
| vector | output | 8 | Synthesized interrupt vector |

## Verification
The trap flag has two writers that can act on the same edge: the decoder strobe sets it and a software write clears it. The bench applies both on one edge and expects the flag to read as set. A second overlap happens when a new strobe arrives while a push is still waiting for its acknowledge. The bench expects the flag to be set again while pushData, bit 6 and the one-pulse redirect keep the values of the first sequence.

// File: rtl/trap_ictl_pkg.sv
package trap_ictl_pkg;
  typedef struct packed {
    logic trapSet;
    logic seqLoad;
  } trapStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PUSH  = 2'd1,
    ST_REDIR = 2'd2
  } seqState_e;
endpackage

// File: rtl/trap_ictl_ctrl.sv
module trap_ictl_ctrl
  import trap_ictl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         undefStrobe,
  input  logic         pushAck,
  output trapStrobes_t strobes,
  output logic         pushReq,
  output logic         redirect
);
  seqState_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:  if (undefStrobe) stateNxt = ST_PUSH;
      ST_PUSH:  if (pushAck) stateNxt = ST_REDIR;
      ST_REDIR: stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strobes.trapSet = undefStrobe;
    strobes.seqLoad = undefStrobe && (state == ST_IDLE);
  end

  assign pushReq  = (state == ST_PUSH);
  assign redirect = (state == ST_REDIR);

  // R7: redirect follows an accepted push
  a_r7_redirect_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    pushReq && pushAck |=> redirect && !pushReq);
  // R7: redirect lasts a single cycle
  a_r7_redirect_pulse: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> !redirect);
  // R6: request held until acknowledged
  a_r6_push_hold: assert property (@(posedge clk) disable iff (!rstN)
    pushReq && !pushAck |=> pushReq);
  // R8: no new sequence starts out of a busy state
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> !pushReq);
endmodule

// File: rtl/trap_ictl_dp.sv
module trap_ictl_dp
  import trap_ictl_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int NUM_LVL = 3,
  parameter int HI_W    = 3,
  parameter int ADDR_W  = 1,
  parameter logic [ADDR_W-1:0]  CTRL_ADDR = 1'b0,
  parameter logic [ADDR_W-1:0]  VEC_ADDR  = 1'b1,
  parameter logic [NUM_LVL-1:0] IEN_RST   = 3'b001
) (
  input  logic              clk,
  input  logic              rstN,
  input  trapStrobes_t      strobes,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWd,
  output logic [7:0]        regRdData,
  input  logic              undefThirdByte,
  input  logic [PC_W-1:0]   pcIn,
  output logic [PC_W-1:0]   pushData,
  input  logic [NUM_LVL-1:0] irqRaw,
  output logic [NUM_LVL-1:0] irqMasked,
  input  logic [8-HI_W-1:0] srcCode,
  output logic [7:0]        vector
);
  localparam int REG_W = 8;
  localparam int SRC_W = REG_W - HI_W;
  localparam int PAD_W = REG_W - 2 - NUM_LVL;

  logic              trapQ, ufoQ;
  logic [NUM_LVL-1:0] ienQ;
  logic [HI_W-1:0]   vecHiQ;
  logic [PC_W-1:0]   pcHold;
  logic              ctrlWr, vecWr;
  logic              unusedWd;

  assign ctrlWr   = regWrEn && (regAddr == CTRL_ADDR);
  assign vecWr    = regWrEn && (regAddr == VEC_ADDR);
  assign unusedWd = ^regWd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapQ  <= 1'b0;
      ufoQ   <= 1'b0;
      ienQ   <= IEN_RST;
      vecHiQ <= '0;
      pcHold <= '0;
    end else begin
      if (strobes.trapSet)          trapQ <= 1'b1;
      else if (ctrlWr && !regWd[7]) trapQ <= 1'b0;
      if (strobes.seqLoad) begin
        ufoQ   <= undefThirdByte;
        pcHold <= pcIn;
      end
      if (ctrlWr) ienQ   <= regWd[NUM_LVL-1:0];
      if (vecWr)  vecHiQ <= regWd[REG_W-1 -: HI_W];
    end
  end

  always_comb begin
    if (regAddr == CTRL_ADDR)
      regRdData = {trapQ, ufoQ, {PAD_W{1'b1}}, ienQ};
    else if (regAddr == VEC_ADDR)
      regRdData = {vecHiQ, {SRC_W{1'b0}}};
    else
      regRdData = '0;
  end

  assign pushData = pcHold;
  assign vector   = {vecHiQ, srcCode};

  for (genvar i = 0; i < NUM_LVL; i++) begin : g_mask
    assign irqMasked[i] = irqRaw[i] & ienQ[i];
  end

  // R2, R4: a strobe always leaves the flag set
  a_r2_strobe_sets: assert property (@(posedge clk) disable iff (!rstN)
    strobes.trapSet |=> trapQ);
  // R3: only a clearing write can drop the flag
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rstN)
    trapQ && !(ctrlWr && !regWd[7]) |=> trapQ);
  // R3: software cannot raise the flag
  a_r3_no_sw_set: assert property (@(posedge clk) disable iff (!rstN)
    !trapQ && !strobes.trapSet |=> !trapQ);
  // R5, R8: byte-position flag and pushed PC only move on sequence start
  a_r5_ufo_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.seqLoad |=> $stable(ufoQ) && $stable(pushData));
  // R10: masked requests never exceed raw requests
  a_r10_mask_subset: assert property (@(posedge clk) disable iff (!rstN)
    (irqMasked & ~irqRaw) == '0);
endmodule

// File: rtl/trap_ictl.sv
module trap_ictl
  import trap_ictl_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int NUM_LVL = 3,
  parameter int HI_W    = 3,
  parameter logic [PC_W-1:0] RESTART_ADDR = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regAddr,
  input  logic               regWrEn,
  input  logic [7:0]         regWd,
  output logic [7:0]         regRdData,
  input  logic               undefStrobe,
  input  logic               undefThirdByte,
  input  logic [PC_W-1:0]    pcIn,
  output logic               pushReq,
  output logic [PC_W-1:0]    pushData,
  input  logic               pushAck,
  output logic               redirect,
  output logic [PC_W-1:0]    redirectAddr,
  input  logic [NUM_LVL-1:0] irqRaw,
  output logic [NUM_LVL-1:0] irqMasked,
  input  logic [8-HI_W-1:0]  srcCode,
  output logic [7:0]         vector
);
  trapStrobes_t strobes;

  trap_ictl_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .undefStrobe (undefStrobe),
    .pushAck     (pushAck),
    .strobes     (strobes),
    .pushReq     (pushReq),
    .redirect    (redirect)
  );

  trap_ictl_dp #(
    .PC_W    (PC_W),
    .NUM_LVL (NUM_LVL),
    .HI_W    (HI_W),
    .ADDR_W  (1)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .regAddr        (regAddr),
    .regWrEn        (regWrEn),
    .regWd          (regWd),
    .regRdData      (regRdData),
    .undefThirdByte (undefThirdByte),
    .pcIn           (pcIn),
    .pushData       (pushData),
    .irqRaw         (irqRaw),
    .irqMasked      (irqMasked),
    .srcCode        (srcCode),
    .vector         (vector)
  );

  assign redirectAddr = RESTART_ADDR;
endmodule

// File: tb/trap_ictl_tb.sv
module trap_ictl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regAddr = 1'b0, regWrEn = 1'b0;
  logic [7:0]  regWd = '0, regRdData;
  logic        undefStrobe = 1'b0, undefThirdByte = 1'b0;
  logic [15:0] pcIn = '0, pushData, redirectAddr;
  logic        pushReq, pushAck = 1'b0, redirect;
  logic [2:0]  irqRaw = '0, irqMasked;
  logic [4:0]  srcCode = '0;
  logic [7:0]  vector;

  int nChecks = 0, nFail = 0;

  always #5 clk = ~clk;

  trap_ictl u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regWd(regWd),
    .regRdData(regRdData), .undefStrobe(undefStrobe), .undefThirdByte(undefThirdByte),
    .pcIn(pcIn), .pushReq(pushReq), .pushData(pushData), .pushAck(pushAck),
    .redirect(redirect), .redirectAddr(redirectAddr), .irqRaw(irqRaw),
    .irqMasked(irqMasked), .srcCode(srcCode), .vector(vector)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    regAddr = a; regWd = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic fireUndef(input logic [15:0] pc, input logic third);
    undefStrobe = 1'b1; pcIn = pc; undefThirdByte = third;
    tick();
    undefStrobe = 1'b0;
  endtask

  task automatic ackPush();
    pushAck = 1'b1;
    tick();
    pushAck = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(1'b0, d); chk("R1", "ctrl after reset", d, 8'h39);
    rd(1'b1, d); chk("R1", "vec after reset", d, 8'h00);
    chk("R1", "pushReq after reset", pushReq, 0);
    chk("R1", "redirect after reset", redirect, 0);
  endtask

  task automatic t_enables();
    logic [7:0] d;
    wr(1'b0, 8'hFE);
    rd(1'b0, d); chk("R9", "enables readback, R3 write 1 no set", d, 8'h3E);
    irqRaw = 3'b111; #1; chk("R10", "mask 111", irqMasked, 3'b110);
    irqRaw = 3'b011; #1; chk("R10", "mask 011", irqMasked, 3'b010);
    irqRaw = 3'b000;
  endtask

  task automatic t_vector();
    logic [7:0] d;
    wr(1'b1, 8'hBF);
    rd(1'b1, d); chk("R11", "vec readback", d, 8'hA0);
    srcCode = 5'h13; #1; chk("R11", "vector merge", vector, 8'hB3);
  endtask

  task automatic t_trapSeq();
    logic [7:0] d;
    fireUndef(16'h1234, 1'b1);
    rd(1'b0, d); chk("R2", "trap flag set, R5 third byte", d, 8'hFE);
    chk("R6", "pushReq raised", pushReq, 1);
    chk("R6", "pushData", pushData, 16'h1234);
    tick();
    chk("R6", "pushReq held", pushReq, 1);
    chk("R6", "redirect low before ack", redirect, 0);
    ackPush();
    chk("R7", "redirect pulse", redirect, 1);
    chk("R7", "redirectAddr", redirectAddr, 16'h0000);
    chk("R7", "pushReq dropped", pushReq, 0);
    tick();
    chk("R7", "redirect one cycle", redirect, 0);
    wr(1'b0, 8'h46);
    rd(1'b0, d); chk("R3", "clear by write 0, R5 read-only", d, 8'h7E);
  endtask

  task automatic t_secondByte();
    logic [7:0] d;
    fireUndef(16'h0042, 1'b0);
    rd(1'b0, d); chk("R5", "second byte", d, 8'hBE);
    chk("R6", "pushData 2nd", pushData, 16'h0042);
    ackPush(); tick();
  endtask

  task automatic t_collision();
    logic [7:0] d;
    regAddr = 1'b0; regWd = 8'h01; regWrEn = 1'b1;
    undefStrobe = 1'b1; pcIn = 16'h2000; undefThirdByte = 1'b1;
    tick();
    regWrEn = 1'b0; undefStrobe = 1'b0;
    rd(1'b0, d); chk("R4", "strobe beats clear", d, 8'hF9);
    ackPush(); tick();
  endtask

  task automatic t_busy();
    logic [7:0] d;
    fireUndef(16'h0100, 1'b0);
    wr(1'b0, 8'h01);
    rd(1'b0, d); chk("R3", "cleared mid-sequence", d, 8'h39);
    fireUndef(16'h0FFF, 1'b1);
    rd(1'b0, d); chk("R8", "busy strobe sets flag only", d, 8'hB9);
    chk("R8", "pushData kept", pushData, 16'h0100);
    ackPush();
    chk("R8", "redirect of first seq", redirect, 1);
    tick();
    chk("R8", "no second push", pushReq, 0);
    chk("R8", "redirect ended", redirect, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    t_reset();
    t_enables();
    t_vector();
    t_trapSeq();
    t_secondByte();
    t_collision();
    t_busy();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule